// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a small serial memory. It watches the raw clock and data lines of a two-wire bus, oversampling them with a fast system clock. It cleans each line with a synchronizer and a persistence filter, then turns the filtered waveforms into bus events: START, STOP, and clock edges. A control byte follows every START. The block answers it only when the upper nibble carries the device code. The three bits below the nibble are chip selects that this block does not decode. The lowest bit selects the direction.

In a write transfer, every byte after the control byte goes to the backend as a one-cycle strobe. In a read transfer, the block takes bytes from the backend and shifts them out, MSB first. It continues for as long as the master acknowledges. The data line is never driven high. The block only asserts an output enable that pulls the line low. That enable changes a fixed number of system clocks after a filtered clock falling edge. While the backend reports that a self-timed write is running, the block gives no acknowledge at all. The master can therefore poll until the memory is ready.

Top module: `eeprom_bus_slave`

## Requirements
- R1: A high-to-low data transition while the clock is high is a START. A low-to-high transition while the clock is high is a STOP. Each produces a one-cycle pulse on `bus_start_o` or `bus_stop_o`. After a START, a control byte whose bits [7:4] are 4'b1010 is acknowledged: `sda_oe_o` is 1 throughout the high phase of the ninth clock.
- R2: Control-byte bits [3:1] have no effect on matching. Both 4'b1010_000x and 4'b1010_111x are acknowledged.
- R3: A control byte with any other upper nibble is not acknowledged. Later bytes of that transfer are neither acknowledged nor delivered on `rx_valid_o`.
- R4: In a write transfer (control bit 0 = 0), each following byte is captured MSB first. It is delivered once on `rx_data_o`, with a one-cycle `rx_valid_o` pulse, and is acknowledged.
- R5: While `busy_i` is 1, not even a matching control byte is acknowledged. Once `busy_i` is 0, the same control byte is acknowledged.
- R6: In a read transfer (control bit 0 = 1), the byte on `tx_data_i` is shifted out MSB first. A 0 bit is sent as `sda_oe_o` = 1. Each byte taken is marked by a one-cycle `tx_take_o` pulse. After that pulse the backend presents the next byte.
- R7: When the master acknowledges a read byte (data low on the ninth clock), the next byte follows. When the master leaves the ninth bit high, the block releases the line and drives nothing until the next START or STOP. A STOP always releases the line.
- R8: A START in the middle of a transfer abandons it, and a partial byte is not delivered. Address matching starts again, and the new control byte is handled normally.
- R9: A pulse shorter than `FILT_LEN` system clocks on either line has no effect. A short low glitch on data during clock high starts no transfer. A short high glitch on clock during clock low adds no bit.
- R10: `sda_oe_o` changes `DRIVE_DLY` clocks after a filtered clock falling edge, and never while the filtered clock is high, except for the release caused by START or STOP. In particular, an acknowledge is still held two system clocks after the raw clock falls.
- R11: After reset, `sda_oe_o`, `rx_valid_o` and `tx_take_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (resolved level) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| busy_i | input | 1 | Backend self-timed write in progress |
| rx_valid_o | output | 1 | One-cycle strobe: received byte valid |
| rx_data_o | output | 8 | Received byte |
| tx_data_i | input | 8 | Byte to send when next taken |
| tx_take_o | output | 1 | One-cycle strobe: `tx_data_i` was loaded |
| bus_start_o | output | 1 | One-cycle pulse per START |
| bus_stop_o | output | 1 | One-cycle pulse per STOP |

## Verification
Each raw edge reaches the engine after the two synchronizer flops, `FILT_LEN` filter clocks and one event register. Any output that follows an SCL edge therefore lags the raw edge by about 14 clocks, and `sda_oe_o` lags by a further `DRIVE_DLY`. The bench holds each quarter bit for 40 clocks. It reads acknowledge and data bits in the middle of the clock-high phase, well after every output has settled. The one deliberately early sample is taken 2 clocks after the raw clock falls, and it checks that the acknowledge is still held. Received bytes are compared by a monitor that pops a queue at the `rx_valid_o` strobe. Any byte delivered when nothing is expected is reported.

// File: rtl/eb_pkg.sv
package eb_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ACKC,
        ST_RX,
        ST_ACKD,
        ST_TX,
        ST_MACK,
        ST_NEXT,
        ST_IGNORE
    } eb_state_e;
endpackage

// File: rtl/eb_glitch_filter.sv
module eb_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   out;
    } flt_t;

    flt_t q, d;
    logic synced;

    assign synced = q.sync[SYNC_STAGES-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], line_i};
        if (synced != q.out) begin
            if (q.cnt == CW'(FILT_LEN - 1)) begin
                d.out = synced;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '1;
            q.cnt  <= '0;
            q.out  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.out;
endmodule

// File: rtl/eb_bus_events.sv
module eb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_ev,
    output logic stop_ev,
    output logic rise_ev,
    output logic fall_ev
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } ev_t;

    ev_t q, d;

    always_comb begin
        d.scl_p = scl_f;
        d.sda_p = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign start_ev = scl_f & q.scl_p & q.sda_p & ~sda_f;
    assign stop_ev  = scl_f & q.scl_p & ~q.sda_p & sda_f;
    assign rise_ev  = scl_f & ~q.scl_p;
    assign fall_ev  = ~scl_f & q.scl_p;
endmodule

// File: rtl/eb_engine.sv
module eb_engine
    import eb_pkg::*;
#(
    parameter logic [3:0] DEV_CODE  = 4'b1010,
    parameter int         DRIVE_DLY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       rise_ev,
    input  logic       fall_ev,
    input  logic       sda_f,
    input  logic       busy_i,
    input  logic [7:0] tx_data_i,
    output logic       sda_oe_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       tx_take_o
);
    localparam int DW = $clog2(DRIVE_DLY + 1);

    typedef struct packed {
        eb_state_e     st;
        logic [3:0]    cnt;
        logic [7:0]    shreg;
        logic          rw;
        logic          oe_tgt;
        logic          oe;
        logic [DW-1:0] dly;
        logic          rx_valid;
        logic [7:0]    rx_data;
        logic          tx_take;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d          = q;
        d.rx_valid = 1'b0;
        d.tx_take  = 1'b0;
        if (q.dly != '0) begin
            d.dly = q.dly - 1'b1;
            if (q.dly == DW'(1)) d.oe = q.oe_tgt;
        end
        if (start_ev || stop_ev) begin
            d.st     = start_ev ? ST_CTRL : ST_IDLE;
            d.cnt    = '0;
            d.oe_tgt = 1'b0;
            d.oe     = 1'b0;
            d.dly    = '0;
        end else if (rise_ev) begin
            case (q.st)
                ST_CTRL, ST_RX: begin
                    d.shreg = {q.shreg[6:0], sda_f};
                    d.cnt   = q.cnt + 1'b1;
                end
                ST_MACK: d.st = sda_f ? ST_IGNORE : ST_NEXT;
                default: ;
            endcase
        end else if (fall_ev) begin
            d.dly = DW'(DRIVE_DLY);
            case (q.st)
                ST_CTRL: if (q.cnt == 4'd8) begin
                    d.cnt = '0;
                    if (q.shreg[7:4] == DEV_CODE && !busy_i) begin
                        d.st     = ST_ACKC;
                        d.rw     = q.shreg[0];
                        d.oe_tgt = 1'b1;
                    end else begin
                        d.st = ST_IGNORE;
                    end
                end
                ST_RX: if (q.cnt == 4'd8) begin
                    d.cnt      = '0;
                    d.rx_valid = 1'b1;
                    d.rx_data  = q.shreg;
                    if (!busy_i) begin
                        d.st     = ST_ACKD;
                        d.oe_tgt = 1'b1;
                    end else begin
                        d.st = ST_IGNORE;
                    end
                end
                ST_ACKC, ST_NEXT: begin
                    if (q.st == ST_NEXT || q.rw) begin
                        d.shreg   = tx_data_i;
                        d.tx_take = 1'b1;
                        d.oe_tgt  = ~tx_data_i[7];
                        d.cnt     = 4'd1;
                        d.st      = ST_TX;
                    end else begin
                        d.oe_tgt = 1'b0;
                        d.cnt    = '0;
                        d.st     = ST_RX;
                    end
                end
                ST_ACKD: begin
                    d.oe_tgt = 1'b0;
                    d.st     = ST_RX;
                end
                ST_TX: begin
                    if (q.cnt == 4'd8) begin
                        d.oe_tgt = 1'b0;
                        d.st     = ST_MACK;
                    end else begin
                        d.shreg  = {q.shreg[6:0], 1'b0};
                        d.oe_tgt = ~q.shreg[6];
                        d.cnt    = q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o   = q.oe;
    assign rx_valid_o = q.rx_valid;
    assign rx_data_o  = q.rx_data;
    assign tx_take_o  = q.tx_take;
endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave #(
    parameter int         FILT_LEN    = 12,
    parameter int         SYNC_STAGES = 2,
    parameter int         DRIVE_DLY   = 4,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       busy_i,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    input  logic [7:0] tx_data_i,
    output logic       tx_take_o,
    output logic       bus_start_o,
    output logic       bus_stop_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    logic scl_f, sda_f;
    logic start_ev, stop_ev, rise_ev, fall_ev;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        eb_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) i_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    eb_bus_events i_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .start_ev(start_ev),
        .stop_ev (stop_ev),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    eb_engine #(
        .DEV_CODE (DEV_CODE),
        .DRIVE_DLY(DRIVE_DLY)
    ) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .sda_f     (sda_f),
        .busy_i    (busy_i),
        .tx_data_i (tx_data_i),
        .sda_oe_o  (sda_oe_o),
        .rx_valid_o(rx_valid_o),
        .rx_data_o (rx_data_o),
        .tx_take_o (tx_take_o)
    );

    assign bus_start_o = start_ev;
    assign bus_stop_o  = stop_ev;
endmodule

// File: rtl/eb_bus_checker.sv
module eb_bus_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic start_ev,
    input logic stop_ev,
    input logic sda_oe_o,
    input logic rx_valid_o,
    input logic tx_take_o
);
    // R10
    oe_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe_o));

    // R4
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R6
    take_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take_o |=> !tx_take_o);

    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe_o);

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o);

    // R1
    cond_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_ev, stop_ev}));
endmodule

bind eeprom_bus_slave eb_bus_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_oe_o  (sda_oe_o),
    .rx_valid_o(rx_valid_o),
    .tx_take_o (tx_take_o)
);

// File: tb/test_eeprom_bus_slave.sv
module test_eeprom_bus_slave;
    localparam int Q = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy = 1'b0;
    logic [7:0] tx_src = 8'hA5;
    logic       sda_line;
    logic       sda_oe_o, rx_valid_o, tx_take_o, bus_start_o, bus_stop_o;
    logic [7:0] rx_data_o;

    int errors = 0;
    int checks = 0;
    int stops_sent = 0;
    int stops_seen = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe_o;

    eeprom_bus_slave i_eeprom_bus_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe_o),
        .busy_i     (busy),
        .rx_valid_o (rx_valid_o),
        .rx_data_o  (rx_data_o),
        .tx_data_i  (tx_src),
        .tx_take_o  (tx_take_o),
        .bus_start_o(bus_start_o),
        .bus_stop_o (bus_stop_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard for received bytes, backend model for transmit bytes
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rx_valid_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R4/R8 unexpected byte", int'(rx_data_o), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data_o == e, "R4 received byte", int'(rx_data_o), int'(e));
                end
            end
            if (tx_take_o) tx_src <= tx_src + 8'h3C;
            if (bus_stop_o) stops_seen++;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start;
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b1; wt(Q);
        stops_sent++;
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m = b;    wt(Q);
        scl_m = 1'b1; wt(Q);
        r = sda_line; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    // bit with a short data glitch in clock-high and a short clock glitch in clock-low
    task automatic m_bit_glitch(input logic b);
        sda_m = b;    wt(Q / 2);
        scl_m = 1'b1; wt(3);
        scl_m = 1'b0; wt(Q / 2 - 3);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(3);
        sda_m = b;    wt(Q - 3);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic m_ack(output logic ack, output logic held);
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        ack = ~sda_line; wt(Q);
        scl_m = 1'b0; wt(2);
        held = sda_oe_o; wt(Q - 2);
    endtask

    task automatic m_write(input logic [7:0] v, output logic ack, output logic held);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(v[i], r);
        m_ack(ack, held);
    endtask

    task automatic m_read(input bit mack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            v[i] = r;
        end
        m_bit(mack ? 1'b0 : 1'b1, r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ack, held, r;
        logic [7:0] v;
        wt(5);
        // R11 reset state
        chk(sda_oe_o == 1'b0, "R11 oe at reset", int'(sda_oe_o), 0);
        chk(rx_valid_o == 1'b0, "R11 rx_valid at reset", int'(rx_valid_o), 0);
        chk(tx_take_o == 1'b0, "R11 tx_take at reset", int'(tx_take_o), 0);
        rst_n = 1'b1;
        wt(20);

        // R1 / R4 / R10: write transfer
        m_start;
        m_write(8'hA0, ack, held);
        chk(ack == 1'b1, "R1 control ack", int'(ack), 1);
        chk(held == 1'b1, "R10 ack held after fall", int'(held), 1);
        exp_q.push_back(8'h05);
        m_write(8'h05, ack, held);
        chk(ack == 1'b1, "R4 data ack", int'(ack), 1);
        exp_q.push_back(8'h3C);
        m_write(8'h3C, ack, held);
        chk(ack == 1'b1, "R4 data ack 2", int'(ack), 1);
        m_stop;

        // R2: chip-select bits ignored
        m_start;
        m_write(8'hAE, ack, held);
        chk(ack == 1'b1, "R2 ack with select bits set", int'(ack), 1);
        exp_q.push_back(8'h7E);
        m_write(8'h7E, ack, held);
        m_stop;

        // R3: mismatch
        m_start;
        m_write(8'h50, ack, held);
        chk(ack == 1'b0, "R3 mismatch no ack", int'(ack), 0);
        m_write(8'h12, ack, held);
        chk(ack == 1'b0, "R3 later byte no ack", int'(ack), 0);
        m_stop;

        // R5: busy polling
        busy = 1'b1;
        m_start;
        m_write(8'hA0, ack, held);
        chk(ack == 1'b0, "R5 no ack while busy", int'(ack), 0);
        m_stop;
        busy = 1'b0;
        m_start;
        m_write(8'hA0, ack, held);
        chk(ack == 1'b1, "R5 ack after busy clears", int'(ack), 1);
        m_stop;

        // R6 / R7: read transfer
        m_start;
        m_write(8'hA1, ack, held);
        chk(ack == 1'b1, "R1 read control ack", int'(ack), 1);
        m_read(1'b1, v);
        chk(v == 8'hA5, "R6 first read byte", int'(v), 'hA5);
        m_read(1'b1, v);
        chk(v == 8'hE1, "R7 byte after master ack", int'(v), 'hE1);
        m_read(1'b0, v);
        chk(v == 8'h1D, "R6 third read byte", int'(v), 'h1D);
        m_read(1'b0, v);
        chk(v == 8'hFF, "R7 released after master nack", int'(v), 'hFF);
        m_stop;
        chk(sda_oe_o == 1'b0, "R7 released after stop", int'(sda_oe_o), 0);

        // R8: repeated start mid byte
        m_start;
        m_write(8'hA0, ack, held);
        for (int i = 0; i < 4; i++) m_bit(1'b1, r);
        m_start;
        m_write(8'hA2, ack, held);
        chk(ack == 1'b1, "R8 control after repeated start", int'(ack), 1);
        exp_q.push_back(8'h66);
        m_write(8'h66, ack, held);
        chk(ack == 1'b1, "R8 data after repeated start", int'(ack), 1);
        m_stop;

        // R9: glitches rejected
        m_start;
        m_write(8'hA0, ack, held);
        exp_q.push_back(8'h81);
        m_bit_glitch(1'b1);
        for (int i = 6; i >= 0; i--) m_bit(i == 0, r);
        m_ack(ack, held);
        chk(ack == 1'b1, "R9 byte after glitches acked", int'(ack), 1);
        m_stop;

        wt(50);
        chk(exp_q.size() == 0, "R4/R9 all bytes delivered", exp_q.size(), 0);
        chk(stops_seen == stops_sent, "R1 stop pulses", stops_seen, stops_sent);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule